// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control store of a multi-channel DMA memory access layer. A processor reaches it over a plain device-control-register bus: a 10-bit register number, a write strobe, a read strobe, 32-bit write data and registered 32-bit read data. Behind that bus sit the following registers:

- a configuration word;
- an error status word and an interrupt enable word;
- channel activate set and activate reset words for each direction;
- end-of-buffer and descriptor-error status words for each direction;
- one descriptor table pointer per transmit channel and per receive channel;
- one buffer size byte per receive channel.

The transmit and receive channel counts are parameters, each from 1 to 32.

The five status words take one-cycle set pulses from the channel engines and are cleared by software writing ones. Writing the configuration word with its top bit set performs a partial soft reset in the same cycle. The soft reset clears the status words, the interrupt enable and both activate-set words. It leaves the activate-reset words, the table pointers and the buffer sizes alone. The configuration word itself takes the masked written value. Descriptor fetch, data movement and interrupt generation are handled elsewhere.

Address decode is done once, into an enumerated register select plus a 5-bit channel index. The write path and the read multiplexer share that decode.

Top module: `dma_ctl_regbank`

## Requirements
- R1: Only these register numbers are decoded: configuration 0x180, error status 0x181, interrupt enable 0x182, TX activate set 0x184, TX activate reset 0x185, TX end-of-buffer 0x186, TX descriptor error 0x187, RX activate set 0x190, RX activate reset 0x191, RX end-of-buffer 0x192, RX descriptor error 0x193, plus the channel ranges of R2. Reading any other number returns zero, and writing it changes no register.
- R2: TX table pointer k is at 0x1A0+k, RX table pointer k at 0x1C0+k and RX buffer size k at 0x1E0+k. A channel index at or beyond the channel count of its direction is treated as not decoded.
- R3: After the hardware reset the configuration reads 0x0007C000 and every other register reads zero.
- R4: A configuration write stores the written value ANDed with 0x00FFC087, so bit 31 never reads back as one.
- R5: A configuration write with bit 31 set clears, in the same cycle, the error status, interrupt enable, both activate-set words and the four direction status words. It leaves the activate-reset words, table pointers and buffer sizes unchanged.
- R6: Writing the error status or any direction status word clears each bit written as one and keeps each bit written as zero.
- R7: Interrupt enable keeps write bits 4:0, the TX activate words keep bits 31:28 and the RX activate words keep bits 31:30. All other bits are stored as zero.
- R8: Buffer size registers store write bits 7:0 only, while table pointers store all 32 bits.
- R9: Read data appears on the port one cycle after the read strobe and holds until the next read. A read and a write of the same register in one cycle return the value from before the write.
- R10: A hardware set pulse on a status bit leaves that bit set after the cycle, even when a software clear or a soft reset hits the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_num | input | 10 | Register number |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err_set | input | 32 | Set pulses for the error status word |
| tx_eob_set | input | 32 | Set pulses for TX end-of-buffer status |
| tx_derr_set | input | 32 | Set pulses for TX descriptor error status |
| rx_eob_set | input | 32 | Set pulses for RX end-of-buffer status |
| rx_derr_set | input | 32 | Set pulses for RX descriptor error status |

## Verification
The properties assume that the strobes, register number, write data and set inputs carry known values once reset is released. They also assume that set pulses may arrive in any cycle, including one in which software writes the same register. The bench changes every input only at the falling clock edge and holds all set inputs at zero except for deliberate one-cycle pulses. Some of those pulses are placed on purpose in the same cycle as a clearing write or a soft-reset write.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam logic [9:0] RN_CFG     = 10'h180;
    localparam logic [9:0] RN_ERR     = 10'h181;
    localparam logic [9:0] RN_IEN     = 10'h182;
    localparam logic [9:0] RN_TXON    = 10'h184;
    localparam logic [9:0] RN_TXOFF   = 10'h185;
    localparam logic [9:0] RN_TXEOB   = 10'h186;
    localparam logic [9:0] RN_TXDERR  = 10'h187;
    localparam logic [9:0] RN_RXON    = 10'h190;
    localparam logic [9:0] RN_RXOFF   = 10'h191;
    localparam logic [9:0] RN_RXEOB   = 10'h192;
    localparam logic [9:0] RN_RXDERR  = 10'h193;
    localparam logic [9:0] RN_TXPTR0  = 10'h1A0;
    localparam logic [9:0] RN_RXPTR0  = 10'h1C0;
    localparam logic [9:0] RN_RXSIZE0 = 10'h1E0;

    localparam logic [31:0] CFG_RST_VAL  = 32'h0007_C000;
    localparam logic [31:0] CFG_WMASK    = 32'h00FF_C087;
    localparam logic [31:0] IEN_WMASK    = 32'h0000_001F;
    localparam logic [31:0] TXACT_WMASK  = 32'hF000_0000;
    localparam logic [31:0] RXACT_WMASK  = 32'hC000_0000;
    localparam int          CFG_SRST_BIT = 31;

    // status word slots
    localparam int ST_ERR    = 0;
    localparam int ST_TXEOB  = 1;
    localparam int ST_TXDERR = 2;
    localparam int ST_RXEOB  = 3;
    localparam int ST_RXDERR = 4;
    localparam int ST_NUM    = 5;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_ERR,
        SEL_IEN,
        SEL_TXON,
        SEL_TXOFF,
        SEL_TXEOB,
        SEL_TXDERR,
        SEL_RXON,
        SEL_RXOFF,
        SEL_RXEOB,
        SEL_RXDERR,
        SEL_TXPTR,
        SEL_RXPTR,
        SEL_RXSIZE
    } reg_sel_e;

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int NTX = 4,
    parameter int NRX = 4
) (
    input  logic [9:0] reg_num,
    output reg_sel_e   sel,
    output logic [4:0] idx
);
    localparam logic [5:0] TX_LIM = 6'(NTX);
    localparam logic [5:0] RX_LIM = 6'(NRX);

    logic tx_in_range;
    logic rx_in_range;

    assign idx         = reg_num[4:0];
    assign tx_in_range = ({1'b0, reg_num[4:0]} < TX_LIM);
    assign rx_in_range = ({1'b0, reg_num[4:0]} < RX_LIM);

    always_comb begin
        sel = SEL_NONE;
        unique case (reg_num)
            RN_CFG:    sel = SEL_CFG;
            RN_ERR:    sel = SEL_ERR;
            RN_IEN:    sel = SEL_IEN;
            RN_TXON:   sel = SEL_TXON;
            RN_TXOFF:  sel = SEL_TXOFF;
            RN_TXEOB:  sel = SEL_TXEOB;
            RN_TXDERR: sel = SEL_TXDERR;
            RN_RXON:   sel = SEL_RXON;
            RN_RXOFF:  sel = SEL_RXOFF;
            RN_RXEOB:  sel = SEL_RXEOB;
            RN_RXDERR: sel = SEL_RXDERR;
            default: begin
                // channel ranges: 32-entry windows, upper bits select the bank
                if (reg_num[9:5] == RN_TXPTR0[9:5] && tx_in_range)
                    sel = SEL_TXPTR;
                else if (reg_num[9:5] == RN_RXPTR0[9:5] && rx_in_range)
                    sel = SEL_RXPTR;
                else if (reg_num[9:5] == RN_RXSIZE0[9:5] && rx_in_range)
                    sel = SEL_RXSIZE;
                else
                    sel = SEL_NONE;
            end
        endcase
    end
endmodule

// File: rtl/dmareg_w1c_reg.sv
module dmareg_w1c_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         sw_clr_en,
    input  logic [W-1:0] sw_clr_mask,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] kept;

    always_comb begin
        if (soft_clr)
            kept = '0;
        else if (sw_clr_en)
            kept = q & ~sw_clr_mask;
        else
            kept = q;
    end

    // hardware set is ORed last so it wins over every clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= kept | hw_set;
    end
endmodule

// File: rtl/dmareg_chan_bank.sv
module dmareg_chan_bank #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [4:0]   idx,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rd_val
);
    logic [N-1:0][W-1:0] ent;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent <= '0;
        end else if (we) begin
            for (int i = 0; i < N; i++) begin
                if (idx == 5'(i))
                    ent[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == 5'(i))
                rd_val = ent[i];
        end
    end
endmodule

// File: rtl/dma_ctl_regbank.sv
module dma_ctl_regbank
    import dmareg_pkg::*;
#(
    parameter int NTX = 4,
    parameter int NRX = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  reg_num,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [31:0] err_set,
    input  logic [31:0] tx_eob_set,
    input  logic [31:0] tx_derr_set,
    input  logic [31:0] rx_eob_set,
    input  logic [31:0] rx_derr_set
);
    reg_sel_e    sel;
    logic [4:0]  idx;
    logic        soft_rst;

    logic [31:0] cfg_q;
    logic [31:0] ier_q;
    logic [31:0] txon_q;
    logic [31:0] txoff_q;
    logic [31:0] rxon_q;
    logic [31:0] rxoff_q;
    logic [31:0] err_q;

    logic [ST_NUM-1:0][31:0] stat_q;
    logic [ST_NUM-1:0][31:0] stat_set;
    logic [ST_NUM-1:0]       stat_clr;

    logic [31:0] txptr_rd;
    logic [31:0] rxptr_rd;
    logic [7:0]  rxsize_rd;
    logic [31:0] rd_mux;
    logic [31:0] rdata_q;

    dmareg_decode #(.NTX(NTX), .NRX(NRX)) u_dec (
        .reg_num (reg_num),
        .sel     (sel),
        .idx     (idx)
    );

    assign soft_rst = wr_en && (sel == SEL_CFG) && wdata[CFG_SRST_BIT];

    // configuration: soft reset value is overwritten by the masked write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RST_VAL;
        else if (wr_en && sel == SEL_CFG)
            cfg_q <= wdata & CFG_WMASK;
    end

    // words cleared by the soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q  <= '0;
            txon_q <= '0;
            rxon_q <= '0;
        end else if (soft_rst) begin
            ier_q  <= '0;
            txon_q <= '0;
            rxon_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_IEN:  ier_q  <= wdata & IEN_WMASK;
                SEL_TXON: txon_q <= wdata & TXACT_WMASK;
                SEL_RXON: rxon_q <= wdata & RXACT_WMASK;
                default:  ;
            endcase
        end
    end

    // activate-reset words: untouched by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txoff_q <= '0;
            rxoff_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_TXOFF: txoff_q <= wdata & TXACT_WMASK;
                SEL_RXOFF: rxoff_q <= wdata & RXACT_WMASK;
                default:   ;
            endcase
        end
    end

    // status words
    always_comb begin
        stat_set[ST_ERR]    = err_set;
        stat_set[ST_TXEOB]  = tx_eob_set;
        stat_set[ST_TXDERR] = tx_derr_set;
        stat_set[ST_RXEOB]  = rx_eob_set;
        stat_set[ST_RXDERR] = rx_derr_set;
        stat_clr[ST_ERR]    = wr_en && (sel == SEL_ERR);
        stat_clr[ST_TXEOB]  = wr_en && (sel == SEL_TXEOB);
        stat_clr[ST_TXDERR] = wr_en && (sel == SEL_TXDERR);
        stat_clr[ST_RXEOB]  = wr_en && (sel == SEL_RXEOB);
        stat_clr[ST_RXDERR] = wr_en && (sel == SEL_RXDERR);
    end

    for (genvar g = 0; g < ST_NUM; g++) begin : g_stat
        dmareg_w1c_reg #(.W(32)) u_stat (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_clr    (soft_rst),
            .sw_clr_en   (stat_clr[g]),
            .sw_clr_mask (wdata),
            .hw_set      (stat_set[g]),
            .q           (stat_q[g])
        );
    end

    assign err_q = stat_q[ST_ERR];

    // per-channel banks
    dmareg_chan_bank #(.N(NTX), .W(32)) u_txptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en && sel == SEL_TXPTR),
        .idx    (idx),
        .wdata  (wdata),
        .rd_val (txptr_rd)
    );

    dmareg_chan_bank #(.N(NRX), .W(32)) u_rxptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en && sel == SEL_RXPTR),
        .idx    (idx),
        .wdata  (wdata),
        .rd_val (rxptr_rd)
    );

    dmareg_chan_bank #(.N(NRX), .W(8)) u_rxsize (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en && sel == SEL_RXSIZE),
        .idx    (idx),
        .wdata  (wdata[7:0]),
        .rd_val (rxsize_rd)
    );

    // read path
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CFG:    rd_mux = cfg_q;
            SEL_ERR:    rd_mux = err_q;
            SEL_IEN:    rd_mux = ier_q;
            SEL_TXON:   rd_mux = txon_q;
            SEL_TXOFF:  rd_mux = txoff_q;
            SEL_TXEOB:  rd_mux = stat_q[ST_TXEOB];
            SEL_TXDERR: rd_mux = stat_q[ST_TXDERR];
            SEL_RXON:   rd_mux = rxon_q;
            SEL_RXOFF:  rd_mux = rxoff_q;
            SEL_RXEOB:  rd_mux = stat_q[ST_RXEOB];
            SEL_RXDERR: rd_mux = stat_q[ST_RXDERR];
            SEL_TXPTR:  rd_mux = txptr_rd;
            SEL_RXPTR:  rd_mux = rxptr_rd;
            SEL_RXSIZE: rd_mux = {24'h0, rxsize_rd};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dmareg_checker.sv
module dmareg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  reg_num,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic [31:0] err_set,
    input logic [31:0] cfg,
    input logic [31:0] ier,
    input logic [31:0] esr
);
    a_r4_cfg_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_num == 10'h180) |=> (cfg == ($past(wdata) & 32'h00FF_C087)));

    a_r5_soft_clears_ien: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_num == 10'h180 && wdata[31]) |=> (ier == 32'h0));

    a_r6_err_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_num == 10'h181)
        |=> (esr == (($past(esr) & ~$past(wdata)) | $past(err_set))));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> ((esr & $past(err_set)) == $past(err_set)));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    a_r1_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_num[9:8] != 2'b01) |=> (rdata == 32'h0));
endmodule

bind dma_ctl_regbank dmareg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_num (reg_num),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .err_set (err_set),
    .cfg     (cfg_q),
    .ier     (ier_q),
    .esr     (err_q)
);

// File: tb/tb_dma_ctl_regbank.sv
`timescale 1ns/1ps
module tb_dma_ctl_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_num = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] err_set = '0;
    logic [31:0] tx_eob_set = '0;
    logic [31:0] tx_derr_set = '0;
    logic [31:0] rx_eob_set = '0;
    logic [31:0] rx_derr_set = '0;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    dma_ctl_regbank #(.NTX(4), .NRX(4)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_num     (reg_num),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wdata       (wdata),
        .rdata       (rdata),
        .err_set     (err_set),
        .tx_eob_set  (tx_eob_set),
        .tx_derr_set (tx_derr_set),
        .rx_eob_set  (rx_eob_set),
        .rx_derr_set (rx_derr_set)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [9:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{4'd7, 10'h182, 32'hFFFF_FFFF, 32'h0000_001F},  // R7 enable mask
        '{4'd7, 10'h184, 32'hFFFF_FFFF, 32'hF000_0000},  // R7 TX set mask
        '{4'd7, 10'h185, 32'h1234_5678, 32'h1000_0000},  // R7 TX reset mask
        '{4'd7, 10'h190, 32'hFFFF_FFFF, 32'hC000_0000},  // R7 RX set mask
        '{4'd7, 10'h191, 32'h7FFF_FFFF, 32'h4000_0000},  // R7 RX reset mask
        '{4'd8, 10'h1A0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R8 full pointer
        '{4'd2, 10'h1A3, 32'h0123_4567, 32'h0123_4567},  // R2 last TX channel
        '{4'd2, 10'h1A4, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 TX index beyond
        '{4'd8, 10'h1C2, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R8 RX pointer
        '{4'd8, 10'h1E1, 32'hABCD_12EF, 32'h0000_00EF},  // R8 size byte
        '{4'd2, 10'h1E4, 32'h0000_00FF, 32'h0000_0000},  // R2 size index beyond
        '{4'd1, 10'h183, 32'hFFFF_FFFF, 32'h0000_0000},  // R1 hole
        '{4'd4, 10'h180, 32'h7FFF_FFFF, 32'h00FF_C087},  // R4 cfg mask
        '{4'd2, 10'h1C4, 32'h0000_0001, 32'h0000_0000}   // R2 RX index beyond
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [31:0] d);
        reg_num = a;
        wdata   = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] a, output logic [31:0] v);
        reg_num = a;
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
        v       = rdata;
    endtask

    task automatic rd_check(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        do_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset values
        rd_check("R3 cfg reset",       10'h180, 32'h0007_C000);
        rd_check("R3 err reset",       10'h181, 32'h0);
        rd_check("R3 ien reset",       10'h182, 32'h0);
        rd_check("R3 txon reset",      10'h184, 32'h0);
        rd_check("R3 txoff reset",     10'h185, 32'h0);
        rd_check("R3 rxeob reset",     10'h192, 32'h0);
        rd_check("R3 txptr reset",     10'h1A0, 32'h0);
        rd_check("R3 rxsize reset",    10'h1E0, 32'h0);

        // vector table: write then read back
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].a, VECS[i].d);
            do_read(VECS[i].a, v);
            check($sformatf("R%0d vector %0d", VECS[i].rq, i), v, VECS[i].e);
        end
        // R1 hole write left neighbours alone
        rd_check("R1 neighbour ien", 10'h182, 32'h0000_001F);
        rd_check("R1 neighbour txon", 10'h184, 32'hF000_0000);
        rd_check("R1 far undecoded", 10'h3FF, 32'h0);

        // R6 write-one-to-clear on error status
        err_set = 32'h0000_F0F0;
        @(negedge clk);
        err_set = '0;
        rd_check("R6 err after set", 10'h181, 32'h0000_F0F0);
        do_write(10'h181, 32'h0000_00F0);
        rd_check("R6 err after clear", 10'h181, 32'h0000_F000);
        do_write(10'h181, 32'h0);
        rd_check("R6 zero write keeps", 10'h181, 32'h0000_F000);

        // R10 set beats clear in same cycle
        tx_eob_set = 32'h1;
        reg_num = 10'h186;
        wdata = 32'h1;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        tx_eob_set = '0;
        rd_check("R10 set over clear", 10'h186, 32'h1);
        do_write(10'h186, 32'h1);
        rd_check("R6 txeob cleared", 10'h186, 32'h0);

        // R9 read and write same cycle returns old value
        reg_num = 10'h1A1;
        wdata = 32'h55AA_55AA;
        wr_en = 1'b1;
        rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check("R9 same-cycle old value", rdata, 32'h0);
        rd_check("R9 new value", 10'h1A1, 32'h55AA_55AA);
        reg_num = 10'h180;
        repeat (3) @(negedge clk);
        check("R9 rdata holds", rdata, 32'h55AA_55AA);

        // R5 soft reset with a simultaneous hardware set (R10)
        reg_num = 10'h180;
        wdata = 32'h8000_0001;
        wr_en = 1'b1;
        rx_derr_set = 32'h4;
        @(negedge clk);
        wr_en = 1'b0;
        rx_derr_set = '0;
        rd_check("R4 cfg after soft", 10'h180, 32'h0000_0001);
        rd_check("R5 err cleared",    10'h181, 32'h0);
        rd_check("R5 ien cleared",    10'h182, 32'h0);
        rd_check("R5 txon cleared",   10'h184, 32'h0);
        rd_check("R5 rxon cleared",   10'h190, 32'h0);
        rd_check("R5 txoff kept",     10'h185, 32'h1000_0000);
        rd_check("R5 rxoff kept",     10'h191, 32'h4000_0000);
        rd_check("R5 txptr kept",     10'h1A0, 32'hDEAD_BEEF);
        rd_check("R5 rxsize kept",    10'h1E1, 32'h0000_00EF);
        rd_check("R10 set over soft", 10'h193, 32'h0000_0004);

        finish_run();
    end
endmodule